// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit linear address into a 36-bit physical address. It does so by reading translation entries from a table hierarchy in memory. A request supplies the linear address, together with a base value that locates the smallest table. The walker then fetches 64-bit entries one at a time through a read port that allows a single outstanding read. It ends with a one-cycle done pulse that carries either the physical address or a fault indication.

The first read goes to a four-entry top table. Linear bits 31..30 select the entry. Each present entry gives the base of the next table in its bits 35..12. Bits 29..21 of the linear address select a directory entry. When that entry has its size flag set, the walk ends there and the result maps a 2 MB page. Otherwise bits 20..12 select an entry in a bottom table, and the result maps a 4 KB page. An entry with its present bit clear stops the walk with a fault.

The block does not cache translations. It does not check access rights and does not write entries back. The memory that answers the reads lies outside the block.

Top module: `pgw_walker`

## Requirements
- R1: After reset, `xl_done`, `xl_fault` and `rd_req` are all 0.
- R2: The first read of a walk goes to address `base_ptr*32 + lin[31:30]*8`, a 36-bit value whose bits 35..32 are 0.
- R3: The second read goes to `{top[35:12], 12'h000} + lin[29:21]*8`, where `top` is the 64-bit top-table entry that was returned.
- R4: If the directory entry `dir` has bit 7 (size) clear, the third read goes to `{dir[35:12], 12'h000} + lin[20:12]*8`.
- R5: A 4 KB walk ends with `xl_phys = {tbl[35:12], lin[11:0]}` and `xl_fault = 0`, where `tbl` is the bottom-table entry.
- R6: If the directory entry has bit 7 set, no third read is issued, and the walk ends with `xl_phys = {dir[35:21], lin[20:0]}` and `xl_fault = 0`.
- R7: If any fetched entry has bit 0 (present) clear, no further read is issued. The walk ends with `xl_done = 1`, `xl_fault = 1` and `xl_phys = 0`.
- R8: The translation result ignores entry bits 63..36. It also ignores every flag bit in 11..1 apart from bit 7 of the directory entry. That includes bit 7 of top and bottom entries.
- R9: Each table level issues exactly one read, as a single-cycle `rd_req` pulse. The next read is never issued before the current one has been answered by `rd_rsp_valid`. A response may arrive in the same cycle as its request.
- R10: A request is taken only while the walker is idle. A `xl_req` raised during a walk, with any address, does not change that walk's reads or its result.
- R11: `xl_done` is a one-cycle pulse, and `xl_fault` is high only together with `xl_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_req | input | 1 | Translation request; taken only when idle |
| xl_lin | input | 32 | Linear address to translate; sampled with `xl_req` |
| base_ptr | input | 27 | Top-table base in 32-byte units; sampled with `xl_req` |
| rd_req | output | 1 | One-cycle pulse starting a memory read |
| rd_addr | output | 36 | Byte address of the entry being read |
| rd_rsp_valid | input | 1 | Memory read data valid |
| rd_rsp_data | input | 64 | Entry returned by memory |
| xl_done | output | 1 | One-cycle pulse marking the end of a walk |
| xl_fault | output | 1 | Walk aborted on a non-present entry; valid with `xl_done` |
| xl_phys | output | 36 | Physical address; valid with `xl_done` when no fault |

## Verification
The hardest case is a response that lands in the same cycle as its read request. At that point the sequencer must advance and issue the next read at once, without dropping a level or adding one. The bench's memory model answers each read after a latency of zero, one or two cycles. It cycles through these latencies across the full sweep of top indices, directory and table indices, page sizes and fault levels. A second hard case is a request that arrives mid-walk. The bench raises one with a different address while the second read is outstanding, then checks that the walk's addresses and result are unchanged. The memory model fills entry bits above 35 and the unused flag bits with junk, so any leak of those bits into an address shows up as a mismatch.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int LIN_W      = 32;
    localparam int PHY_W      = 36;
    localparam int ENT_W      = 64;
    localparam int BASE_W     = 27;
    localparam int BASE_ALIGN = 5;
    localparam int ENT_SHIFT  = 3;
    localparam int PG_SHIFT   = 12;
    localparam int BIG_SHIFT  = 21;
    localparam int IDX_W      = 9;
    localparam int TOP_IDX_W  = 2;
    localparam int PRESENT_B  = 0;
    localparam int SIZE_B     = 7;
    localparam int FRM_W      = PHY_W - PG_SHIFT;
    localparam int BIG_FRM_W  = PHY_W - BIG_SHIFT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_TOP,
        ST_FETCH_DIR,
        ST_FETCH_TBL,
        ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        LV_TOP,
        LV_DIR,
        LV_TBL
    } level_e;

    typedef struct packed {
        walk_st_e           st;
        logic               issued;
        logic [LIN_W-1:0]   lin;
        logic [PHY_W-1:0]   addr;
        logic [PHY_W-1:0]   phys;
        logic               fault;
    } walk_regs_t;
endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
    import pgw_pkg::*;
#(
    parameter int P_LIN_W  = LIN_W,
    parameter int P_PHY_W  = PHY_W,
    parameter int P_ENT_W  = ENT_W,
    parameter int P_BASE_W = BASE_W
) (
    input  level_e               level,
    input  logic [P_BASE_W-1:0]  base_ptr,
    input  logic [P_LIN_W-1:0]   lin,
    input  logic [P_ENT_W-1:0]   entry,
    output logic [P_PHY_W-1:0]   addr
);
    localparam int PAD_W = P_PHY_W - P_BASE_W - BASE_ALIGN;
    localparam int DIR_LO = BIG_SHIFT;
    localparam int TBL_LO = PG_SHIFT;
    localparam int TOP_LO = P_LIN_W - TOP_IDX_W;

    logic [P_PHY_W-1:0] tbl_base;
    logic [IDX_W-1:0]   idx;

    always_comb begin
        if (level == LV_TOP) begin
            tbl_base = {{PAD_W{1'b0}}, base_ptr, {BASE_ALIGN{1'b0}}};
            idx      = {{(IDX_W-TOP_IDX_W){1'b0}}, lin[TOP_LO +: TOP_IDX_W]};
        end else begin
            tbl_base = {entry[P_PHY_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
            if (level == LV_DIR) idx = lin[DIR_LO +: IDX_W];
            else                 idx = lin[TBL_LO +: IDX_W];
        end
        addr = tbl_base + {{(P_PHY_W-IDX_W-ENT_SHIFT){1'b0}}, idx, {ENT_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/pgw_frame_sel.sv
module pgw_frame_sel
    import pgw_pkg::*;
#(
    parameter int P_LIN_W = LIN_W,
    parameter int P_PHY_W = PHY_W,
    parameter int P_ENT_W = ENT_W
) (
    input  logic               big,
    input  logic [P_ENT_W-1:0] entry,
    input  logic [P_LIN_W-1:0] lin,
    output logic [P_PHY_W-1:0] phys
);
    always_comb begin
        if (big) phys = {entry[P_PHY_W-1:BIG_SHIFT], lin[BIG_SHIFT-1:0]};
        else     phys = {entry[P_PHY_W-1:PG_SHIFT], lin[PG_SHIFT-1:0]};
    end
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
#(
    parameter int P_LIN_W = LIN_W,
    parameter int P_PHY_W = PHY_W,
    parameter int P_ENT_W = ENT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [P_LIN_W-1:0] req_lin,
    input  logic               rsp_valid,
    input  logic [P_ENT_W-1:0] rsp_data,
    input  logic [P_PHY_W-1:0] calc_addr,
    input  logic [P_PHY_W-1:0] calc_phys,
    output level_e             calc_level,
    output logic [P_LIN_W-1:0] calc_lin,
    output logic               calc_big,
    output logic               rd_req,
    output logic [P_PHY_W-1:0] rd_addr,
    output logic               done,
    output logic               fault,
    output logic [P_PHY_W-1:0] phys
);
    walk_regs_t q, d;
    logic in_fetch;
    logic present;

    assign in_fetch = (q.st == ST_FETCH_TOP) || (q.st == ST_FETCH_DIR) ||
                      (q.st == ST_FETCH_TBL);
    assign present  = rsp_data[PRESENT_B];

    always_comb begin
        d          = q;
        calc_level = LV_TOP;
        calc_lin   = q.lin;
        calc_big   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                calc_lin = req_lin;
                if (req_valid) begin
                    d.st     = ST_FETCH_TOP;
                    d.lin    = req_lin;
                    d.addr   = calc_addr;
                    d.issued = 1'b0;
                    d.fault  = 1'b0;
                    d.phys   = '0;
                end
            end
            ST_FETCH_TOP: begin
                calc_level = LV_DIR;
                d.issued   = 1'b1;
                if (rsp_valid) begin
                    if (!present) begin
                        d.st    = ST_DONE;
                        d.fault = 1'b1;
                    end else begin
                        d.st     = ST_FETCH_DIR;
                        d.addr   = calc_addr;
                        d.issued = 1'b0;
                    end
                end
            end
            ST_FETCH_DIR: begin
                calc_level = LV_TBL;
                calc_big   = 1'b1;
                d.issued   = 1'b1;
                if (rsp_valid) begin
                    if (!present) begin
                        d.st    = ST_DONE;
                        d.fault = 1'b1;
                    end else if (rsp_data[SIZE_B]) begin
                        d.st   = ST_DONE;
                        d.phys = calc_phys;
                    end else begin
                        d.st     = ST_FETCH_TBL;
                        d.addr   = calc_addr;
                        d.issued = 1'b0;
                    end
                end
            end
            ST_FETCH_TBL: begin
                calc_level = LV_TBL;
                d.issued   = 1'b1;
                if (rsp_valid) begin
                    d.st = ST_DONE;
                    if (!present) d.fault = 1'b1;
                    else          d.phys  = calc_phys;
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.issued <= 1'b0;
            q.lin    <= '0;
            q.addr   <= '0;
            q.phys   <= '0;
            q.fault  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_req  = in_fetch && !q.issued;
    assign rd_addr = q.addr;
    assign done    = (q.st == ST_DONE);
    assign fault   = done && q.fault;
    assign phys    = q.phys;

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rsp_valid) |=> !rd_req);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);
    // R2
    top_low4g_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && q.st == ST_FETCH_TOP) |-> (rd_addr[P_PHY_W-1:32] == '0));
    // R10
    lin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> $stable(q.lin));
    // R7
    fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fetch && rsp_valid && !rsp_data[PRESENT_B]) |=> (done && fault && !rd_req));
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
#(
    parameter int P_LIN_W  = LIN_W,
    parameter int P_PHY_W  = PHY_W,
    parameter int P_ENT_W  = ENT_W,
    parameter int P_BASE_W = BASE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xl_req,
    input  logic [P_LIN_W-1:0]  xl_lin,
    input  logic [P_BASE_W-1:0] base_ptr,
    output logic                rd_req,
    output logic [P_PHY_W-1:0]  rd_addr,
    input  logic                rd_rsp_valid,
    input  logic [P_ENT_W-1:0]  rd_rsp_data,
    output logic                xl_done,
    output logic                xl_fault,
    output logic [P_PHY_W-1:0]  xl_phys
);
    level_e             calc_level;
    logic [P_LIN_W-1:0] calc_lin;
    logic               calc_big;
    logic [P_PHY_W-1:0] calc_addr;
    logic [P_PHY_W-1:0] calc_phys;

    pgw_seq #(
        .P_LIN_W(P_LIN_W), .P_PHY_W(P_PHY_W), .P_ENT_W(P_ENT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (xl_req),
        .req_lin    (xl_lin),
        .rsp_valid  (rd_rsp_valid),
        .rsp_data   (rd_rsp_data),
        .calc_addr  (calc_addr),
        .calc_phys  (calc_phys),
        .calc_level (calc_level),
        .calc_lin   (calc_lin),
        .calc_big   (calc_big),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .done       (xl_done),
        .fault      (xl_fault),
        .phys       (xl_phys)
    );

    pgw_addr_gen #(
        .P_LIN_W(P_LIN_W), .P_PHY_W(P_PHY_W), .P_ENT_W(P_ENT_W), .P_BASE_W(P_BASE_W)
    ) u_addr (
        .level    (calc_level),
        .base_ptr (base_ptr),
        .lin      (calc_lin),
        .entry    (rd_rsp_data),
        .addr     (calc_addr)
    );

    pgw_frame_sel #(
        .P_LIN_W(P_LIN_W), .P_PHY_W(P_PHY_W), .P_ENT_W(P_ENT_W)
    ) u_frame (
        .big   (calc_big),
        .entry (rd_rsp_data),
        .lin   (calc_lin),
        .phys  (calc_phys)
    );
endmodule

// File: tb/pgw_walker_bench.sv
module pgw_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_req = 1'b0;
    logic [31:0] xl_lin = '0;
    logic [26:0] base_ptr = '0;
    logic        rd_req;
    logic [35:0] rd_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        xl_done;
    logic        xl_fault;
    logic [35:0] xl_phys;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    pgw_walker u_pgw_walker (
        .clk(clk), .rst_n(rst_n), .xl_req(xl_req), .xl_lin(xl_lin),
        .base_ptr(base_ptr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .xl_done(xl_done), .xl_fault(xl_fault), .xl_phys(xl_phys)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model: entry content computed from its address and level (1..3).
    // Junk in bits 63..36 and in flag bits 11..1; size bit set on top and
    // bottom levels as junk (R8).
    function automatic logic [63:0] ent(input logic [35:0] a, input int lvl,
                                        input int np_lvl, input bit big);
        logic [23:0] frm;
        logic [11:0] fl;
        logic [63:0] e;
        frm = a[26:3] * 24'd40503 + 24'h001234 + 24'(lvl);
        fl  = 12'hF7E;
        if (lvl != 2 || big) fl[7] = 1'b1;
        fl[0] = (lvl != np_lvl);
        e = {28'hDEADBEE ^ a[27:0], frm, fl};
        return e;
    endfunction

    task automatic walk(input logic [31:0] lin, input logic [26:0] base,
                        input int np, input bit big, input int lat, input bit intrude);
        logic [35:0] ea [1:3];
        logic [63:0] ee [1:3];
        int          exp_reads;
        bit          exp_fault;
        logic [35:0] exp_phys;
        int          nreads;
        int          cnt;
        bit          pending;
        bit          seen_done;
        logic [35:0] cur_addr;

        ea[1] = {4'h0, base, 5'b0} + {31'b0, lin[31:30], 3'b0};
        ee[1] = ent(ea[1], 1, np, big);
        ea[2] = {ee[1][35:12], 12'h000} + {24'b0, lin[29:21], 3'b0};
        ee[2] = ent(ea[2], 2, np, big);
        ea[3] = {ee[2][35:12], 12'h000} + {24'b0, lin[20:12], 3'b0};
        ee[3] = ent(ea[3], 3, np, big);
        exp_fault = 1'b0;
        exp_phys  = '0;
        if (np == 1)      begin exp_reads = 1; exp_fault = 1'b1; end
        else if (np == 2) begin exp_reads = 2; exp_fault = 1'b1; end
        else if (big)     begin exp_reads = 2; exp_phys = {ee[2][35:21], lin[20:0]}; end
        else if (np == 3) begin exp_reads = 3; exp_fault = 1'b1; end
        else              begin exp_reads = 3; exp_phys = {ee[3][35:12], lin[11:0]}; end

        @(negedge clk);
        xl_req = 1'b1; xl_lin = lin; base_ptr = base;
        @(negedge clk);
        xl_req = 1'b0; xl_lin = ~lin; base_ptr = ~base;
        nreads = 0; cnt = 0; pending = 0; seen_done = 0; cur_addr = '0;
        for (int c = 0; c < 60; c++) begin
            if (rd_rsp_valid) rd_rsp_valid = 1'b0;
            if (xl_done) begin seen_done = 1; break; end
            if (rd_req) begin
                nreads++;
                cur_addr = rd_addr;
                if (pending)
                    chk(0, "R9", "read issued before response", 64'(nreads), 64'(nreads-1));
                if (nreads <= 3)
                    chk(rd_addr == ea[nreads], nreads == 1 ? "R2" : (nreads == 2 ? "R3" : "R4"),
                        "read address", 64'(rd_addr), 64'(ea[nreads]));
                pending = 1; cnt = lat;
                if (intrude && nreads == 2) begin
                    xl_req = 1'b1; xl_lin = lin ^ 32'hC0F0_3FFF;
                end
                if (intrude && nreads == 3) xl_req = 1'b0;
            end
            if (pending) begin
                if (cnt == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = (nreads <= 3) ? ent(cur_addr, nreads, np, big) : 64'h0;
                    pending = 0;
                end else cnt--;
            end
            @(negedge clk);
        end
        xl_req = 1'b0;
        chk(seen_done, intrude ? "R10" : "R11", "done seen", 64'(seen_done), 64'd1);
        chk(nreads == exp_reads, big && np != 1 ? "R6" : "R9", "read count",
            64'(nreads), 64'(exp_reads));
        chk(xl_fault == exp_fault, "R7", "fault flag", 64'(xl_fault), 64'(exp_fault));
        chk(xl_phys == exp_phys, exp_fault ? "R7" : (big ? "R6" : "R5"),
            intrude ? "phys after intruding request (R10)" : "phys (R8 junk ignored)",
            64'(xl_phys), 64'(exp_phys));
        @(negedge clk);
        chk(!xl_done && !xl_fault && !rd_req, "R11", "done pulse width",
            64'({xl_done, xl_fault, rd_req}), 64'd0);
    endtask

    initial begin
        logic [26:0] bases [3];
        int k;
        bases[0] = 27'h0000001;
        bases[1] = 27'h7FFFFFF;
        bases[2] = 27'h1234567;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!xl_done && !xl_fault && !rd_req, "R1", "reset outputs",
            64'({xl_done, xl_fault, rd_req}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!xl_done && !xl_fault && !rd_req, "R1", "idle after reset",
            64'({xl_done, xl_fault, rd_req}), 64'd0);
        k = 0;
        for (int b = 0; b < 3; b++)
            for (int t = 0; t < 4; t++)
                for (int di = 0; di < 4; di++)
                    for (int ti = 0; ti < 2; ti++)
                        for (int bg = 0; bg < 2; bg++) begin
                            logic [8:0]  dv;
                            logic [31:0] l;
                            dv = (di == 0) ? 9'd0 : (di == 1) ? 9'd1 : (di == 2) ? 9'd255 : 9'd511;
                            l = {t[1:0], dv, (ti == 0) ? 9'd0 : 9'd511, 12'(k * 397)};
                            walk(l, bases[b], 0, bg[0], k % 3, 1'b0);
                            k++;
                        end
        // R7 faults at each level
        for (int np = 1; np <= 3; np++)
            for (int t = 0; t < 4; t++)
                for (int bg = 0; bg < 2; bg++) begin
                    walk({t[1:0], 9'(np * 77), 9'(t * 33), 12'hABC}, bases[t % 3], np, bg[0], (np + t) % 3, 1'b0);
                end
        // R10 intruding requests
        for (int i = 0; i < 6; i++)
            walk({2'(i), 9'(i * 91), 9'(i * 57), 12'(i * 301)}, bases[i % 3], 0, i[0], i % 3, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule